// File: doc/BRIEF.md
# Interrupt Wakeup Event Generator

This block lives in an always-on power domain. It sits between a wide set of shared peripheral interrupt lines and a downstream interrupt controller. Every line passes straight through to the controller with no clocked stage. The only change on that path is that two fixed lines are flipped in polarity. Those two lines come from active-low external system pins, and the flip makes the downstream side see every line as active-high.

Beside the passthrough path, the block keeps one bank of enable words for each of two CPUs. Each word covers 32 lines. A processor or power controller reaches the words over a small memory-mapped register port. For each CPU, the block raises a registered wakeup request whenever any line is active and that CPU has the line enabled. The power sequencer uses this request to bring a sleeping CPU back. The interrupt lines are taken through a two-flop synchronizer before the wakeup logic sees them. The wakeup logic works on the polarity-corrected values.

Top module: `wkup_event_gen`

## Requirements
- R1: `irq_out[n]` equals `irq_in[n]` combinationally for every line n other than the two inverted lines, whatever the enable words hold.
- R2: Lines 7 and 119 reach `irq_out` inverted (`irq_out[7] = ~irq_in[7]`, `irq_out[119] = ~irq_in[119]`).
- R3: Register decode works as follows. `reg_addr[10]` selects the CPU (0 or 1). `reg_addr[9:2]` selects the word index. Line n sits in word n>>5 at bit n mod 32. A write with `reg_en=1, reg_we=1` stores `reg_wdata` at the rising edge. A read (`reg_en=1, reg_we=0`) returns the stored word on `reg_rdata` in the same cycle.
- R4: While `rst` is high at a rising edge, every enable word clears to zero and both bits of `wake_req` go to 0.
- R5: `wake_req[c]` is the registered OR over all lines of (synchronized, polarity-corrected line AND CPU c's enable bit). After a write changes an enable word at edge E, `wake_req` shows the new value after edge E+1.
- R6: A change on `irq_in` first shows on `wake_req` after the third rising edge that follows it. Two edges are spent in the synchronizer and one in the output register.
- R7: The wakeup logic uses the corrected polarity of lines 7 and 119. Holding one of them low wakes a CPU that enables it. Holding it high does not.
- R8: An out-of-range access reads as zero, and a write to it changes no enable word. An access is out of range when its word index is not below the bank count, when `reg_addr[11]` is 1, or when `reg_addr[1:0]` is not 0.
- R9: Writing 32'hFFFF_FFFF to a word enables all 32 of its lines. Writing 0 masks them all.
- R10: The two CPUs' enable banks are independent. A line wakes only the CPUs that enable it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_BANKS*32 | Incoming interrupt lines |
| irq_out | output | NUM_BANKS*32 | Lines forwarded to the downstream controller |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| wake_req | output | 2 | Per-CPU wakeup request |

## Verification
A table of cases is run against the wakeup function. Each case sets one active line and one enabled line per CPU. The table covers these patterns:
- the active line matching a CPU's enable, which shows that the bit mapping is right;
- a neighbouring bit enabled instead, which catches off-by-one errors in the bank and bit indexing;
- the same line enabled on one CPU or on both, which separates shared wakeups from per-CPU ones;
- the top line of the last bank, which exposes a truncated bank count;
- the two inverted pins held at their idle high level and driven low, which shows whether inversion comes before the wakeup logic.

Directed cases then cover the following:
- an arbitrary wide input pattern on the passthrough path;
- all-ones and all-zeros words;
- addresses that alias when bit 11 or the low bits are ignored;
- the exact edge on which `wake_req` responds to an enable write and to an input change.

// File: rtl/wkg_pkg.sv
package wkg_pkg;

    localparam int WORD_W   = 32;
    localparam int NUM_CPUS = 2;
    localparam int ADDR_W   = 12;
    localparam int CPU_BIT  = 10;   // 0x400 between per-CPU blocks
    localparam int IDX_LSB  = 2;    // 4-byte word spacing
    localparam int IDX_W    = 8;

    typedef struct packed {
        logic             hit;
        logic             cpu;
        logic [IDX_W-1:0] idx;
    } reg_sel_t;

    // Decode a byte address into CPU/word select; hit only for legal words.
    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int                banks);
        reg_sel_t s;
        s.cpu = a[CPU_BIT];
        s.idx = a[CPU_BIT-1:IDX_LSB];
        s.hit = (a[ADDR_W-1] == 1'b0) && (a[IDX_LSB-1:0] == '0) &&
                (int'(s.idx) < banks);
        return s;
    endfunction

endpackage

// File: rtl/wkg_polarity.sv
module wkg_polarity #(
    parameter int NUM_LINES  = 160,
    parameter int INV_LINE_A = 7,
    parameter int INV_LINE_B = 119
) (
    input  logic [NUM_LINES-1:0] raw_lines,
    output logic [NUM_LINES-1:0] fixed_lines
);
    logic [NUM_LINES-1:0] flip_mask;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_mask
        if (i == INV_LINE_A || i == INV_LINE_B) begin : g_inv
            assign flip_mask[i] = 1'b1;
        end else begin : g_pass
            assign flip_mask[i] = 1'b0;
        end
    end

    assign fixed_lines = raw_lines ^ flip_mask;

endmodule

// File: rtl/wkg_sync.sv
module wkg_sync #(
    parameter int WIDTH = 160
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;
    logic [1:0]       since_rst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

    // Tracks how many edges have passed since reset, for the latency check.
    always_ff @(posedge clk) begin
        if (rst)                   since_rst_q <= '0;
        else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
    end

    AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (rst)
        (since_rst_q >= 2'd2) |-> (sync_out == $past(async_in, 2))); // R6

endmodule

// File: rtl/wkg_enable_regs.sv
module wkg_enable_regs
    import wkg_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    localparam int NUM_LINES = NUM_BANKS * WORD_W
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                reg_en,
    input  logic                                reg_we,
    input  logic [ADDR_W-1:0]                   reg_addr,
    input  logic [WORD_W-1:0]                   reg_wdata,
    output logic [WORD_W-1:0]                   reg_rdata,
    output logic [NUM_CPUS-1:0][NUM_LINES-1:0]  en_lines
);
    reg_sel_t sel;
    logic     wr_fire;

    assign sel     = decode_addr(reg_addr, NUM_BANKS);
    assign wr_fire = reg_en && reg_we && sel.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_lines <= '0;
        end else if (wr_fire) begin
            for (int c = 0; c < NUM_CPUS; c++) begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (sel.cpu == 1'(c) && sel.idx == IDX_W'(b))
                        en_lines[c][b*WORD_W +: WORD_W] <= reg_wdata;
                end
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_en && !reg_we && sel.hit) begin
            for (int c = 0; c < NUM_CPUS; c++) begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (sel.cpu == 1'(c) && sel.idx == IDX_W'(b))
                        reg_rdata = en_lines[c][b*WORD_W +: WORD_W];
                end
            end
        end
    end

    AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_en && !reg_we && !sel.hit) |-> (reg_rdata == '0)); // R8

    for (genvar gc = 0; gc < NUM_CPUS; gc++) begin : g_cpu_chk
        for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank_chk
            AST_WORD_STORED: assert property (@(posedge clk) disable iff (rst)
                (reg_en && reg_we && sel.hit && sel.cpu == 1'(gc) &&
                 sel.idx == IDX_W'(gb))
                |=> (en_lines[gc][gb*WORD_W +: WORD_W] == $past(reg_wdata))); // R3
            AST_MISS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
                (reg_en && reg_we && !sel.hit)
                |=> $stable(en_lines[gc][gb*WORD_W +: WORD_W])); // R8
        end
    end

endmodule

// File: rtl/wkg_wake_detect.sv
module wkg_wake_detect
    import wkg_pkg::*;
#(
    parameter int NUM_LINES = 160
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_LINES-1:0]               lines,
    input  logic [NUM_CPUS-1:0][NUM_LINES-1:0] en_lines,
    output logic [NUM_CPUS-1:0]                wake_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wake_q <= '0;
        end else begin
            for (int c = 0; c < NUM_CPUS; c++)
                wake_q[c] <= |(lines & en_lines[c]);
        end
    end

    for (genvar gc = 0; gc < NUM_CPUS; gc++) begin : g_chk
        AST_WAKE_FOLLOWS_ENABLED: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (wake_q[gc] == $past(|(lines & en_lines[gc])))); // R5
    end

endmodule

// File: rtl/wkup_event_gen.sv
module wkup_event_gen
    import wkg_pkg::*;
#(
    parameter int NUM_BANKS  = 5,
    parameter int INV_LINE_A = 7,
    parameter int INV_LINE_B = 119,
    localparam int NUM_LINES = NUM_BANKS * WORD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic [NUM_LINES-1:0] irq_out,
    input  logic                 reg_en,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic [NUM_CPUS-1:0]  wake_req
);
    logic [NUM_LINES-1:0]               fixed_lines;
    logic [NUM_LINES-1:0]               synced_lines;
    logic [NUM_CPUS-1:0][NUM_LINES-1:0] en_lines;

    wkg_polarity #(
        .NUM_LINES (NUM_LINES),
        .INV_LINE_A(INV_LINE_A),
        .INV_LINE_B(INV_LINE_B)
    ) i_polarity (
        .raw_lines  (irq_in),
        .fixed_lines(fixed_lines)
    );

    assign irq_out = fixed_lines;

    wkg_sync #(.WIDTH(NUM_LINES)) i_sync (
        .clk     (clk),
        .rst     (rst),
        .async_in(fixed_lines),
        .sync_out(synced_lines)
    );

    wkg_enable_regs #(.NUM_BANKS(NUM_BANKS)) i_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_en   (reg_en),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .en_lines (en_lines)
    );

    wkg_wake_detect #(.NUM_LINES(NUM_LINES)) i_wake (
        .clk     (clk),
        .rst     (rst),
        .lines   (synced_lines),
        .en_lines(en_lines),
        .wake_q  (wake_req)
    );

    AST_NO_WAKE_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (en_lines == '0) |=> (wake_req == '0)); // R5 R10

endmodule

// File: tb/test_wkup_event_gen.sv
module test_wkup_event_gen;
    localparam int NB = 5;
    localparam int NL = NB * 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] irq_in = '0;
    logic [NL-1:0] irq_out;
    logic          reg_en = 1'b0;
    logic          reg_we = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [1:0]    wake_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    wkup_event_gen i_wkup_event_gen (
        .clk(clk), .rst(rst), .irq_in(irq_in), .irq_out(irq_out),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_req(wake_req)
    );

    function automatic logic [NL-1:0] inv_mask();
        logic [NL-1:0] m = '0;
        m[7] = 1'b1;
        m[119] = 1'b1;
        return m;
    endfunction

    function automatic logic [NL-1:0] idle_lines();
        return inv_mask();   // inverted pins idle high
    endfunction

    task automatic check(input string req, input logic [159:0] act,
                         input logic [159:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_en = 1'b0;
    endtask

    function automatic logic [11:0] addr_of(input int cpu, input int line);
        return 12'((cpu << 10) | ((line >> 5) << 2));
    endfunction

    task automatic clear_all();
        for (int c = 0; c < 2; c++)
            for (int b = 0; b < NB; b++)
                bus_write(12'((c << 10) | (b << 2)), 32'h0);
    endtask

    typedef struct packed {
        int act;
        int en0;
        int en1;
        bit e0;
        bit e1;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{act: 3,   en0: 3,   en1: -1,  e0: 1'b1, e1: 1'b0},
        '{act: 3,   en0: 4,   en1: 3,   e0: 1'b0, e1: 1'b1},
        '{act: 40,  en0: 40,  en1: 40,  e0: 1'b1, e1: 1'b1},
        '{act: 159, en0: 159, en1: -1,  e0: 1'b1, e1: 1'b0},
        '{act: 7,   en0: 7,   en1: -1,  e0: 1'b1, e1: 1'b0},
        '{act: 119, en0: -1,  en1: 119, e0: 1'b0, e1: 1'b1},
        '{act: -1,  en0: 7,   en1: 119, e0: 1'b0, e1: 1'b0},
        '{act: 32,  en0: 31,  en1: 33,  e0: 1'b0, e1: 1'b0},
        '{act: 0,   en0: 0,   en1: 0,   e0: 1'b1, e1: 1'b1}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [NL-1:0] pat;

        irq_in = idle_lines();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R4: reset state
        check("R4 wake", 160'(wake_req), 160'(0));
        for (int c = 0; c < 2; c++)
            for (int b = 0; b < NB; b++) begin
                bus_read(12'((c << 10) | (b << 2)), rd);
                check("R4 word", 160'(rd), 160'(0));
            end

        // R1 R2: passthrough with an arbitrary pattern
        @(negedge clk);
        pat = {32'hDEADBEEF, 32'h0123_4567, 32'h89AB_CDEF, 32'hF0F0_0F0F, 32'h5A5A_A5A5};
        irq_in = pat;
        #1 check("R1 R2 passthrough", 160'(irq_out), 160'(pat ^ inv_mask()));
        pat[7] = ~pat[7]; pat[119] = ~pat[119];
        irq_in = pat;
        #1 check("R2 inverted pins", 160'({irq_out[119], irq_out[7]}),
                 160'({~pat[119], ~pat[7]}));
        irq_in = idle_lines();

        // R5 R7 R10: vector table
        foreach (VECS[i]) begin
            clear_all();
            if (VECS[i].en0 >= 0)
                bus_write(addr_of(0, VECS[i].en0), 32'(1) << (VECS[i].en0 % 32));
            if (VECS[i].en1 >= 0)
                bus_write(addr_of(1, VECS[i].en1), 32'(1) << (VECS[i].en1 % 32));
            pat = idle_lines();
            if (VECS[i].act >= 0) pat[VECS[i].act] = ~pat[VECS[i].act];
            @(negedge clk);
            irq_in = pat;
            repeat (4) @(negedge clk);
            check("R5 R7 R10 wake cpu0", 160'(wake_req[0]), 160'(VECS[i].e0));
            check("R5 R7 R10 wake cpu1", 160'(wake_req[1]), 160'(VECS[i].e1));
            check("R1 R2 passthrough vec", 160'(irq_out), 160'(pat ^ inv_mask()));
            irq_in = idle_lines();
        end

        // R3: readback with CPU select and index
        clear_all();
        bus_write(12'h408, 32'hCAFE_1234);
        bus_write(12'h010, 32'h8000_0001);
        bus_read(12'h408, rd); check("R3 cpu1 word2", 160'(rd), 160'(32'hCAFE_1234));
        bus_read(12'h008, rd); check("R3 cpu0 word2", 160'(rd), 160'(0));
        bus_read(12'h010, rd); check("R3 cpu0 word4", 160'(rd), 160'(32'h8000_0001));

        // R8: out-of-range accesses
        bus_write(12'h014, 32'hFFFF_FFFF);
        bus_read(12'h014, rd); check("R8 index past banks", 160'(rd), 160'(0));
        bus_write(12'hC08, 32'h1111_1111);
        bus_read(12'h408, rd); check("R8 bit11 write ignored", 160'(rd), 160'(32'hCAFE_1234));
        bus_write(12'h011, 32'h0);
        bus_read(12'h010, rd); check("R8 misaligned write ignored", 160'(rd), 160'(32'h8000_0001));
        bus_read(12'h80C, rd); check("R8 bit11 read zero", 160'(rd), 160'(0));

        // R9: all-ones / all-zeros
        clear_all();
        @(negedge clk);
        pat = idle_lines(); pat[50] = 1'b1;
        irq_in = pat;
        bus_write(12'h004, 32'hFFFF_FFFF);
        repeat (4) @(negedge clk);
        check("R9 unmask all", 160'(wake_req), 160'(2'b01));
        bus_write(12'h004, 32'h0);
        repeat (2) @(negedge clk);
        check("R9 mask all", 160'(wake_req), 160'(2'b00));

        // R5: enable-write latency; write lands at edge E
        bus_write(12'h404, 32'h0004_0000);   // line 50 for cpu1
        check("R5 not before E+1", 160'(wake_req), 160'(2'b00));
        @(negedge clk);
        check("R5 after E+1", 160'(wake_req), 160'(2'b10));

        // R6: input latency of three edges
        @(negedge clk);
        irq_in = idle_lines();
        repeat (4) @(negedge clk);
        check("R6 idle", 160'(wake_req), 160'(2'b00));
        irq_in = pat;
        repeat (2) @(negedge clk);
        check("R6 not after two edges", 160'(wake_req), 160'(2'b00));
        @(negedge clk);
        check("R6 after third edge", 160'(wake_req), 160'(2'b10));

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule